// File: doc/BRIEF.md
# Multi-Address I2C Slave Address Matcher

This block decides whether a 7-bit slave address, received in the first byte of an I2C transfer, selects this device. The bit-level receiver hands over the whole address byte, already deserialized, together with a one-cycle valid strobe. The block compares the upper seven bits of that byte against four programmable slave addresses. Each address has its own mask, and a mask bit set to 1 turns that address bit into a "don't care". The all-zero General Call address is recognised separately. No mask ever affects it, and each slot carries its own enable for it.

On a hit, the block gives a one-cycle match pulse, the index of the slot that matched, and a flag that marks a General Call. It also keeps the full received byte, including the R/W bit, in a capture register. Software can read that register back to learn which concrete address caused a masked match.

A simple register port gives write and read access to the four slave-address registers, the four mask registers and the capture register. Select values 0 to 3 pick the address registers, 4 to 7 pick the mask registers and 8 picks the capture register. Reads are combinational.

Top module: `multi_addr_matcher`

## Requirements
- R1: A received byte whose bits 7:1 equal a slot's programmed address bits 7:1 produces `match_o` = 1 with `match_idx_o` equal to that slot's number (0 to 3). Slot addresses are written at select 0 to 3.
- R2: A mask register (select 4 + slot) uses bits 7:1, one for each address bit in the same position. A mask bit at 1 makes that address bit match whatever was received. A mask bit at 0 requires equality.
- R3: After reset, every address, mask and enable bit reads 0, and `match_o`, `gc_o`, `match_idx_o` and the capture register are 0. With masks at 0, a nonzero address matches only when every bit is equal.
- R4: A received address of seven zeros never produces an ordinary slot match. It is reported as a General Call (`match_o` = 1, `gc_o` = 1) only if at least one slot has its enable set, which is bit 0 of its address register. `match_idx_o` is then the lowest enabled slot, and mask contents have no effect.
- R5: Mask registers keep only bits 7:1. Bit 0 and every bit above 7 ignore writes and read as 0. Address registers keep bits 7:0, and their bits above 7 read as 0.
- R6: On a match, the whole received byte is stored and can be read at select 8. An address byte that does not match leaves the stored value unchanged.
- R7: `match_o` is high for exactly the one cycle after the clock edge at which `addr_valid_i` was sampled high with a hit. Without a valid strobe, no pulse is produced. Strobes on back-to-back cycles give back-to-back pulses.
- R8: When several slots match the same address, `match_idx_o` reports the lowest-numbered one.
- R9: Bit 0 of the address byte (R/W) takes no part in matching, and it is stored along with the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 4 | Register select: 0-3 address, 4-7 mask, 8 capture |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| addr_byte_i | input | 8 | Received address byte, bits 7:1 address, bit 0 R/W |
| addr_valid_i | input | 1 | One-cycle strobe qualifying `addr_byte_i` |
| match_o | output | 1 | One-cycle match pulse |
| gc_o | output | 1 | The match is a General Call |
| match_idx_o | output | 2 | Index of the matching slot |

## Verification
Every match result (`match_o`, `gc_o`, `match_idx_o`) and the capture register update on the clock edge that samples `addr_valid_i`. They are therefore due one edge after the strobe is driven. Register reads are combinational and are due in the same cycle as the select.

The driver raises the strobe at a falling edge and pushes its prediction into a queue. The monitor wakes at each rising edge, waits a nanosecond and pops exactly one prediction for each strobe. In every cycle without a strobe, it requires `match_o` to be low. Capture and register contents are read back at a falling edge, after the edge that wrote them.

// File: rtl/mam_pkg.sv
package mam_pkg;

    // 7-bit slave address field carried in bits 7:1 of an address byte
    typedef logic [6:0] addr7_t;

    localparam addr7_t GC_ADDR = 7'b000_0000;

    function automatic addr7_t addr_field(input logic [7:0] b);
        return b[7:1];
    endfunction

endpackage

// File: rtl/mam_regfile.sv
module mam_regfile
    import mam_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned CFG_DW    = 32,
    parameter int unsigned SEL_W     = 4
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            we_i,
    input  logic [SEL_W-1:0]                sel_i,
    input  logic [CFG_DW-1:0]               wdata_i,
    input  logic [7:0]                      cap_i,
    output logic [CFG_DW-1:0]               rdata_o,
    output logic [NUM_SLOTS-1:0][6:0]       slot_addr_o,
    output logic [NUM_SLOTS-1:0][6:0]       slot_mask_o,
    output logic [NUM_SLOTS-1:0]            gc_en_o
);

    localparam int unsigned MASK_BASE = NUM_SLOTS;
    localparam int unsigned CAP_SEL   = 2 * NUM_SLOTS;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][6:0] addr;
        logic [NUM_SLOTS-1:0][6:0] mask;
        logic [NUM_SLOTS-1:0]      gcen;
    } regs_t;

    regs_t regs_d, regs_q;

    // Upper write-data bits are deliberately dropped
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[CFG_DW-1:8];

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            for (int unsigned i = 0; i < NUM_SLOTS; i++) begin
                if (sel_i == SEL_W'(i)) begin
                    regs_d.addr[i] = addr_field(wdata_i[7:0]);
                    regs_d.gcen[i] = wdata_i[0];
                end
                if (sel_i == SEL_W'(MASK_BASE + i)) begin
                    regs_d.mask[i] = addr_field(wdata_i[7:0]);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int unsigned i = 0; i < NUM_SLOTS; i++) begin
            if (sel_i == SEL_W'(i)) begin
                rdata_o[7:0] = {regs_q.addr[i], regs_q.gcen[i]};
            end
            if (sel_i == SEL_W'(MASK_BASE + i)) begin
                rdata_o[7:0] = {regs_q.mask[i], 1'b0};
            end
        end
        if (sel_i == SEL_W'(CAP_SEL)) begin
            rdata_o[7:0] = cap_i;
        end
    end

    assign slot_addr_o = regs_q.addr;
    assign slot_mask_o = regs_q.mask;
    assign gc_en_o     = regs_q.gcen;

endmodule

// File: rtl/mam_lane.sv
module mam_lane
    import mam_pkg::*;
(
    input  addr7_t rx_i,
    input  addr7_t slot_i,
    input  addr7_t mask_i,
    output logic   hit_o
);

    addr7_t diff;

    always_comb begin
        diff  = (rx_i ^ slot_i) & ~mask_i;
        // The general-call pattern is never an ordinary slot hit
        hit_o = (diff == '0) && (rx_i != GC_ADDR);
    end

endmodule

// File: rtl/mam_pick.sv
module mam_pick #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned IDX_W     = 2
) (
    input  logic [NUM_SLOTS-1:0] lane_hit_i,
    input  logic [NUM_SLOTS-1:0] gc_en_i,
    input  logic                 is_gc_i,
    output logic                 found_o,
    output logic                 gc_o,
    output logic [IDX_W-1:0]     idx_o
);

    logic [NUM_SLOTS-1:0] cand;

    always_comb begin
        cand    = is_gc_i ? gc_en_i : lane_hit_i;
        found_o = |cand;
        gc_o    = is_gc_i && (|gc_en_i);
        idx_o   = '0;
        // Scan downward so the lowest set candidate is taken last
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/multi_addr_matcher.sv
module multi_addr_matcher
    import mam_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned CFG_DW    = 32,
    parameter int unsigned IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    parameter int unsigned SEL_W     = $clog2(2 * NUM_SLOTS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    output logic [CFG_DW-1:0] cfg_rdata_o,
    input  logic [7:0]        addr_byte_i,
    input  logic              addr_valid_i,
    output logic              match_o,
    output logic              gc_o,
    output logic [IDX_W-1:0]  match_idx_o
);

    typedef struct packed {
        logic             hit;
        logic             gc;
        logic [IDX_W-1:0] idx;
        logic [7:0]       cap;
    } res_t;

    res_t res_d, res_q;

    logic [NUM_SLOTS-1:0][6:0] slot_addr;
    logic [NUM_SLOTS-1:0][6:0] slot_mask;
    logic [NUM_SLOTS-1:0]      gc_en;
    logic [NUM_SLOTS-1:0]      lane_hit;
    logic                      pick_found;
    logic                      pick_gc;
    logic [IDX_W-1:0]          pick_idx;
    logic [7:0]                cap_q;
    addr7_t                    rx_addr;

    assign rx_addr = addr_field(addr_byte_i);
    assign cap_q   = res_q.cap;

    mam_regfile #(
        .NUM_SLOTS (NUM_SLOTS),
        .CFG_DW    (CFG_DW),
        .SEL_W     (SEL_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (cfg_we_i),
        .sel_i       (cfg_sel_i),
        .wdata_i     (cfg_wdata_i),
        .cap_i       (cap_q),
        .rdata_o     (cfg_rdata_o),
        .slot_addr_o (slot_addr),
        .slot_mask_o (slot_mask),
        .gc_en_o     (gc_en)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
        mam_lane u_lane (
            .rx_i   (rx_addr),
            .slot_i (slot_addr[g]),
            .mask_i (slot_mask[g]),
            .hit_o  (lane_hit[g])
        );
    end

    mam_pick #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_pick (
        .lane_hit_i (lane_hit),
        .gc_en_i    (gc_en),
        .is_gc_i    (rx_addr == GC_ADDR),
        .found_o    (pick_found),
        .gc_o       (pick_gc),
        .idx_o      (pick_idx)
    );

    always_comb begin
        res_d     = res_q;
        res_d.hit = 1'b0;
        res_d.gc  = 1'b0;
        if (addr_valid_i && pick_found) begin
            res_d.hit = 1'b1;
            res_d.gc  = pick_gc;
            res_d.idx = pick_idx;
            res_d.cap = addr_byte_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign match_o     = res_q.hit;
    assign gc_o        = res_q.gc;
    assign match_idx_o = res_q.idx;

endmodule

// File: rtl/mam_checker.sv
module mam_checker #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned CFG_DW    = 32,
    parameter int unsigned SEL_W     = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              addr_valid_i,
    input logic [7:0]        addr_byte_i,
    input logic              match_o,
    input logic              gc_o,
    input logic [7:0]        cap_q,
    input logic [SEL_W-1:0]  cfg_sel_i,
    input logic [CFG_DW-1:0] cfg_rdata_o
);

    logic sel_is_mask;
    assign sel_is_mask = (int'(cfg_sel_i) >= int'(NUM_SLOTS)) &&
                         (int'(cfg_sel_i) <  int'(2 * NUM_SLOTS));

    assert_pulse_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> $past(addr_valid_i));

    assert_gc_is_zero_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gc_o |-> (match_o && cap_q[7:1] == 7'd0));

    assert_slot_hit_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o && !gc_o) |-> (cap_q[7:1] != 7'd0));

    assert_capture_on_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> (cap_q == $past(addr_byte_i)));

    assert_capture_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !match_o |-> $stable(cap_q));

    assert_mask_read_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_is_mask |-> (cfg_rdata_o[0] == 1'b0 && cfg_rdata_o[CFG_DW-1:8] == '0));

endmodule

bind multi_addr_matcher mam_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .CFG_DW    (CFG_DW),
    .SEL_W     (SEL_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_valid_i (addr_valid_i),
    .addr_byte_i  (addr_byte_i),
    .match_o      (match_o),
    .gc_o         (gc_o),
    .cap_q        (cap_q),
    .cfg_sel_i    (cfg_sel_i),
    .cfg_rdata_o  (cfg_rdata_o)
);

// File: tb/sim_multi_addr_matcher.sv
`timescale 1ns/1ps
module sim_multi_addr_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  addr_byte = '0;
    logic        addr_valid = 1'b0;
    logic        match;
    logic        gc;
    logic [1:0]  midx;

    int checks = 0;
    int errors = 0;
    bit mon_on = 0;

    typedef struct {
        logic       m;
        logic       g;
        logic [1:0] idx;
        string      tag;
    } exp_t;

    exp_t sb[$];

    logic [6:0] m_addr [4];
    logic [6:0] m_mask [4];
    logic       m_gcen [4];
    logic [7:0] m_cap;

    always #4 clk = ~clk;   // 125 MHz

    multi_addr_matcher u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_sel_i    (cfg_sel),
        .cfg_wdata_i  (cfg_wdata),
        .cfg_rdata_o  (cfg_rdata),
        .addr_byte_i  (addr_byte),
        .addr_valid_i (addr_valid),
        .match_o      (match),
        .gc_o         (gc),
        .match_idx_o  (midx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [7:0] b, input string tag);
        exp_t e;
        logic [6:0] a = b[7:1];
        e.m = 0; e.g = 0; e.idx = 0; e.tag = tag;
        if (a == 7'd0) begin
            for (int i = 3; i >= 0; i--) if (m_gcen[i]) begin e.m = 1; e.g = 1; e.idx = 2'(i); end
        end else begin
            for (int i = 3; i >= 0; i--)
                if (((a ^ m_addr[i]) & ~m_mask[i]) == 7'd0) begin e.m = 1; e.idx = 2'(i); end
        end
        return e;
    endfunction

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        if (sel < 4) begin m_addr[sel] = d[7:1]; m_gcen[sel] = d[0]; end
        else if (sel < 8) m_mask[sel-4] = d[7:1];
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(input logic [3:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    // Drive one strobe per byte on consecutive cycles
    task automatic send(input logic [7:0] b [], input string tag);
        foreach (b[k]) begin
            exp_t e;
            @(negedge clk);
            e = predict(b[k], tag);
            if (e.m) m_cap = b[k];
            sb.push_back(e);
            addr_byte = b[k]; addr_valid = 1;
        end
        @(negedge clk);
        addr_valid = 0;
        @(negedge clk);
    endtask

    // Monitor: one prediction per strobe, quiet otherwise
    initial begin
        forever begin
            @(posedge clk);
            if (mon_on) begin
                if (sb.size() != 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    #1;
                    check({e.tag, " match"}, 32'(match), 32'(e.m));
                    check({e.tag, " gc"}, 32'(gc), 32'(e.g));
                    if (e.m) check({e.tag, " idx"}, 32'(midx), 32'(e.idx));
                end else begin
                    #1;
                    check("R7 no pulse without strobe", 32'(match), 32'd0);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_addr[i] = 0; m_mask[i] = 0; m_gcen[i] = 0; end
        m_cap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R3: reset state
        check("R3 match after reset", 32'(match), 0);
        check("R3 gc after reset", 32'(gc), 0);
        check("R3 idx after reset", 32'(midx), 0);
        for (int s = 0; s < 9; s++) rd(4'(s), 32'd0, "R3 register reset value");
        mon_on = 1;

        // R4/R3: zero address without enables, nonzero address vs zeroed slots
        send('{8'h00, 8'hA0}, "R3 R4 unprogrammed");

        // R1: exact addresses
        wr(0, 32'hA0); wr(1, 32'h44); wr(2, 32'h60); wr(3, 32'h7E);
        send('{8'hA0, 8'h44, 8'h60, 8'h7E, 8'h42}, "R1 exact");
        rd(8, 32'h7E, "R6 capture after match");

        // R9: R/W bit ignored and captured
        send('{8'hA1, 8'h45}, "R9 rw bit");
        rd(8, 32'h45, "R9 R6 capture keeps rw bit");

        // R6: no-match leaves capture
        send('{8'hE2}, "R6 miss");
        rd(8, 32'h45, "R6 capture hold on miss");

        // R2: mask address bits 1:0 on slot 2 (mask bits 2:1)
        wr(6, 32'h06);
        send('{8'h67, 8'h64, 8'h68}, "R2 masked");
        rd(8, 32'h64, "R2 R6 actual address after masked match");

        // R8: slot 3 equal to slot 2 pattern, slot 2 wins
        wr(3, 32'h62);
        send('{8'h62}, "R8 priority 2 over 3");
        // slot 1 fully masked: matches all nonzero not hitting slot 0
        wr(5, 32'hFE);
        send('{8'h62, 8'hA0, 8'hFE}, "R8 R2 full mask slot1");

        // R4: general call, masks irrelevant, enables choose index
        send('{8'h00}, "R4 gc disabled");
        wr(2, 32'h61);
        send('{8'h01}, "R4 gc slot2");
        wr(1, 32'h45);
        send('{8'h00}, "R4 gc lowest enabled");
        rd(8, 32'h00, "R4 R6 gc capture");

        // R5: register widths
        wr(4, 32'hFFFF_FFFF);
        rd(4, 32'h0000_00FE, "R5 mask bit0 and high bits");
        wr(0, 32'hFFFF_FF5B);
        rd(0, 32'h0000_005B, "R5 address high bits");
        rd(1, 32'h0000_0045, "R5 neighbour untouched");

        // R7: back-to-back strobes
        send('{8'hB6, 8'h5A, 8'h00}, "R7 back to back");

        // drain then summary
        repeat (3) @(posedge clk);
        mon_on = 0;
        check("R7 scoreboard drained", 32'(sb.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule